// File: doc/BRIEF.md
# TLB Address Translation Unit

This block turns 32-bit virtual addresses into physical addresses for load and store requests. It uses a small, fully associative translation cache, and each entry maps one 4 KB page. A request carries a virtual address, an access size (word or byte), a direction flag and the data lanes involved. The unit answers in the same cycle, without a clock edge, with a physical address and a fault indication. One clock later it presents the same outcome as a registered response, together with the faulting virtual address.

Software-visible maintenance works through three inputs:

- A page-table base write stores a new base value and empties the cache.
- An invalidate-all input empties the cache without touching the base.
- A single-page invalidate drops only the entry that maps a given address.

New mappings come in through a fill port. The unit neither walks page tables nor retries a failed translation. Whoever issued the request decides what to do after a fault.

The unit also formats data for the memory side. A byte read is zero-extended from the addressed lane. A byte write copies the low byte of the store data to every lane and enables only the addressed lane.

Top module: `tlb_xlate`

## Requirements
- R1: A request whose page has a valid entry, and that raises no other fault, yields the physical address {frame number, virtual address bits 11:0} with both fault flags low.
- R2: A word request with virtual address bits 1:0 not equal to zero raises the alignment fault and not the access fault, whatever the cache holds.
- R3: A byte request never raises the alignment fault, for any value of address bits 1:0.
- R4: A request whose page matches no valid entry raises the access fault, and the physical address output is zero.
- R5: A write request to a page whose entry has the writable bit clear raises the access fault. A read of that page translates normally.
- R6: A write to the page-table base register stores the new value, which is visible on the base output the next cycle, and leaves every entry invalid.
- R7: The invalidate-all input leaves every entry invalid and does not change the base register.
- R8: A single-page invalidate clears only the entry whose page matches the given address. When nothing matches, every mapping stays as it was.
- R9: A fill whose page is already cached overwrites that entry. Otherwise the fill goes to the lowest-numbered invalid entry.
- R10: When every entry is valid and the fill page is not cached, the entry named by a replacement pointer is replaced. The pointer starts at entry 0 after reset and advances by one, wrapping, after each such replacement only.
- R11: When maintenance operations arrive in the same cycle, base write and invalidate-all take precedence over single-page invalidate, which takes precedence over fill. A lower-precedence operation in that cycle is dropped. Lookups in a cycle see the entries as they were before that cycle's edge.
- R12: The response is registered. rsp_valid follows req_valid by one cycle and carries that request's fault flags and physical address. The fault-address output holds the request's virtual address on a fault and zero otherwise. After reset, rsp_valid is low.
- R13: A byte read returns memory lane bits 1:0 of the address (lane 0 = bits 7:0, little-endian), zero-extended to 32 bits. A byte write drives the low store byte on all four lanes with only that lane's byte enable set. A word access passes the read data through and enables all four lanes. Enables are zero unless the request is a write that translates without fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address of the request |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data |
| mem_rdata | input | 32 | Word read from memory at the translated address |
| xl_paddr | output | 32 | Same-cycle physical address, zero on fault |
| xl_align_fault | output | 1 | Same-cycle alignment fault |
| xl_access_fault | output | 1 | Same-cycle access fault |
| rd_data | output | 32 | Formatted load result |
| st_data | output | 32 | Formatted store data |
| st_be | output | 4 | Store byte enables |
| rsp_valid | output | 1 | Registered response valid |
| rsp_paddr | output | 32 | Registered physical address |
| rsp_align_fault | output | 1 | Registered alignment fault |
| rsp_access_fault | output | 1 | Registered access fault |
| rsp_fault_addr | output | 32 | Registered faulting virtual address |
| ptb_we | input | 1 | Write page-table base (flushes cache) |
| ptb_wdata | input | 32 | New page-table base value |
| ptb_q | output | 32 | Current page-table base |
| inv_all | input | 1 | Invalidate every entry |
| inv_one | input | 1 | Invalidate the entry mapping inv_vaddr |
| inv_vaddr | input | 32 | Address whose page is invalidated |
| fill_valid | input | 1 | Install a mapping |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_writable | input | 1 | Writable permission of the mapping |

## Verification
A corrupted valid bit, page tag, frame number or replacement pointer is hidden until a request touches the affected page. The bench therefore keeps requesting pages it has filled, evicted and invalidated. Any such error then shows as a wrong physical address or a spurious or missing access fault on the same-cycle outputs, and on the registered response one clock later. A wrong replacement pointer is caught when an evicted page still hits, or when a page that should be resident misses, on the first lookup after the fill. The reference model tracks every entry and the pointer. It compares all outputs on every clock, so a mismatch is reported in the cycle it first reaches the pins.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   req_byte,
  input  logic                   req_write,
  input  logic [31:0]            req_wdata,
  input  logic [31:0]            mem_rdata,
  output logic [PA_W-1:0]        xl_paddr,
  output logic                   xl_align_fault,
  output logic                   xl_access_fault,
  output logic [31:0]            rd_data,
  output logic [31:0]            st_data,
  output logic [3:0]             st_be,
  output logic                   rsp_valid,
  output logic [PA_W-1:0]        rsp_paddr,
  output logic                   rsp_align_fault,
  output logic                   rsp_access_fault,
  output logic [VA_W-1:0]        rsp_fault_addr,
  input  logic                   ptb_we,
  input  logic [31:0]            ptb_wdata,
  output logic [31:0]            ptb_q,
  input  logic                   inv_all,
  input  logic                   inv_one,
  input  logic [VA_W-1:0]        inv_vaddr,
  input  logic                   fill_valid,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn,
  input  logic [PA_W-OFF_W-1:0]  fill_pfn,
  input  logic                   fill_writable
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;

  logic [ENTRIES-1:0] vld, wok;
  logic [VPN_W-1:0]   tag [ENTRIES];
  logic [PFN_W-1:0]   frm [ENTRIES];
  logic [IDX_W-1:0]   rr;
  logic [31:0]        ptb;

  logic [ENTRIES-1:0] lhit, ihit, fhit_v;
  logic [IDX_W-1:0]   lidx, fidx, free_idx, fmatch_idx;
  logic               any_free, fhit;

  wire [VPN_W-1:0] req_vpn = req_vaddr[VA_W-1:OFF_W];
  wire [VPN_W-1:0] inv_vpn = inv_vaddr[VA_W-1:OFF_W];
  wire             flush   = ptb_we | inv_all;
  wire             inv_go  = inv_one & ~flush;
  wire             fill_go = fill_valid & ~flush & ~inv_one;

  always_comb begin
    lidx = '0;
    fmatch_idx = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      lhit[i]   = vld[i] && tag[i] == req_vpn;
      ihit[i]   = vld[i] && tag[i] == inv_vpn;
      fhit_v[i] = vld[i] && tag[i] == fill_vpn;
      if (lhit[i]) lidx = IDX_W'(i);
      if (fhit_v[i]) fmatch_idx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
  end

  assign fhit = |fhit_v;
  assign fidx = fhit ? fmatch_idx : (any_free ? free_idx : rr);

  wire hit     = |lhit;
  wire mis     = req_valid & ~req_byte & |req_vaddr[1:0];
  wire acc     = req_valid & ~mis & (~hit | (req_write & ~wok[lidx]));
  wire good    = req_valid & ~mis & ~acc;
  wire [1:0] lane = req_vaddr[1:0];
  wire [31:0] shifted = mem_rdata >> {lane, 3'b000};

  assign xl_align_fault  = mis;
  assign xl_access_fault = acc;
  assign xl_paddr = good ? {frm[lidx], req_vaddr[OFF_W-1:0]} : '0;
  assign rd_data  = req_byte ? {24'h0, shifted[7:0]} : mem_rdata;
  assign st_data  = req_byte ? {4{req_wdata[7:0]}} : req_wdata;
  assign st_be    = (good & req_write) ? (req_byte ? 4'b0001 << lane : 4'hF) : 4'h0;
  assign ptb_q    = ptb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      wok <= '0;
      rr  <= '0;
      ptb <= '0;
    end else begin
      if (ptb_we) ptb <= ptb_wdata;
      if (flush) vld <= '0;
      else if (inv_go) vld <= vld & ~ihit;
      else if (fill_go) begin
        vld[fidx] <= 1'b1;
        wok[fidx] <= fill_writable;
        if (!fhit && !any_free) rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag[fidx] <= fill_vpn;
      frm[fidx] <= fill_pfn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid        <= 1'b0;
      rsp_paddr        <= '0;
      rsp_align_fault  <= 1'b0;
      rsp_access_fault <= 1'b0;
      rsp_fault_addr   <= '0;
    end else begin
      rsp_valid        <= req_valid;
      rsp_paddr        <= xl_paddr;
      rsp_align_fault  <= mis;
      rsp_access_fault <= acc;
      rsp_fault_addr   <= (mis | acc) ? req_vaddr : '0;
    end
  end

  // R12
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  align_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_byte && req_vaddr[1:0] != 2'b00) |=>
      (rsp_align_fault && !rsp_access_fault && rsp_fault_addr == $past(req_vaddr)));

  // R3
  byte_never_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_byte) |=> !rsp_align_fault);

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptb_we || inv_all) |=> vld == '0);

  // R8
  inv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_go |=> vld == ($past(vld) & ~$past(ihit)));

  // R9
  fill_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !fhit && any_free) |=> $countones(vld) == $countones($past(vld)) + 1);

  // R1
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_align_fault, rsp_access_fault}));
endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_byte = 0, req_write = 0;
  logic [31:0] req_vaddr = 0, req_wdata = 0, mem_rdata = 0;
  logic [31:0] xl_paddr, rd_data, st_data, rsp_paddr, rsp_fault_addr, ptb_q;
  logic        xl_align_fault, xl_access_fault, rsp_valid, rsp_align_fault, rsp_access_fault;
  logic [3:0]  st_be;
  logic        ptb_we = 0, inv_all = 0, inv_one = 0, fill_valid = 0, fill_writable = 0;
  logic [31:0] ptb_wdata = 0, inv_vaddr = 0;
  logic [19:0] fill_vpn = 0, fill_pfn = 0;

  tlb_xlate u0 (.*);

  int compared = 0, mismatched = 0;
  bit done = 0;

  bit        m_v [8];
  bit        m_w [8];
  int        m_tag [8];
  int        m_frm [8];
  int        m_rr = 0;
  bit [31:0] m_ptb = 0;
  bit        e_rv = 0, e_ra = 0, e_rc = 0;
  bit [31:0] e_rp = 0, e_rf = 0;
  bit        n_rv, n_ra, n_rc;
  bit [31:0] n_rp, n_rf;

  task automatic chk(string tag, bit [31:0] act, bit [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int find(int vpn);
    for (int i = 0; i < 8; i++) if (m_v[i] && m_tag[i] == vpn) return i;
    return -1;
  endfunction

  task automatic compare();
    int k;
    bit a, c, ok;
    bit [31:0] p, rd, sd;
    bit [3:0] be;
    int ln;
    k  = find(int'(req_vaddr[31:12]));
    a  = req_valid && !req_byte && req_vaddr[1:0] != 0;
    c  = req_valid && !a && (k < 0 || (req_write && !m_w[k]));
    ok = req_valid && !a && !c;
    p  = ok ? {m_frm[k][19:0], req_vaddr[11:0]} : 32'h0;
    ln = int'(req_vaddr[1:0]);
    rd = req_byte ? (mem_rdata >> (8 * ln)) & 32'hFF : mem_rdata;
    sd = req_byte ? {4{req_wdata[7:0]}} : req_wdata;
    be = (ok && req_write) ? (req_byte ? 4'(1 << ln) : 4'hF) : 4'h0;
    chk("R2 xl_align_fault", 32'(xl_align_fault), 32'(a));
    chk("R3 byte no align", 32'(req_byte & xl_align_fault), 0);
    chk("R4/R5 xl_access_fault", 32'(xl_access_fault), 32'(c));
    chk("R1 xl_paddr", xl_paddr, p);
    chk("R13 rd_data", rd_data, rd);
    chk("R13 st_data", st_data, sd);
    chk("R13 st_be", 32'(st_be), 32'(be));
    chk("R6 ptb_q", ptb_q, m_ptb);
    chk("R12 rsp_valid", 32'(rsp_valid), 32'(e_rv));
    chk("R12 rsp_align", 32'(rsp_align_fault), 32'(e_ra));
    chk("R12 rsp_access", 32'(rsp_access_fault), 32'(e_rc));
    chk("R12 rsp_paddr", rsp_paddr, e_rp);
    chk("R12 rsp_fault_addr", rsp_fault_addr, e_rf);
    n_rv = req_valid; n_ra = a; n_rc = c; n_rp = p;
    n_rf = (a || c) ? req_vaddr : 32'h0;
  endtask

  task automatic model_edge();
    int k;
    e_rv = n_rv; e_ra = n_ra; e_rc = n_rc; e_rp = n_rp; e_rf = n_rf;
    if (ptb_we) m_ptb = ptb_wdata;
    if (ptb_we || inv_all) begin
      for (int i = 0; i < 8; i++) m_v[i] = 0;
    end else if (inv_one) begin
      k = find(int'(inv_vaddr[31:12]));
      if (k >= 0) m_v[k] = 0;
    end else if (fill_valid) begin
      k = find(int'(fill_vpn));
      if (k < 0) for (int i = 7; i >= 0; i--) if (!m_v[i]) k = i;
      if (k < 0) begin
        k = m_rr;
        m_rr = (m_rr + 1) % 8;
      end
      m_v[k] = 1; m_w[k] = fill_writable;
      m_tag[k] = int'(fill_vpn); m_frm[k] = int'(fill_pfn);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    @(posedge clk);
    if (rst_n) model_edge();
    #1;
  endtask

  task automatic quiet();
    req_valid = 0; ptb_we = 0; inv_all = 0; inv_one = 0; fill_valid = 0;
  endtask

  task automatic fill(int vpn, int pfn, bit w);
    quiet(); fill_valid = 1; fill_vpn = 20'(vpn); fill_pfn = 20'(pfn); fill_writable = w;
    step(); quiet();
  endtask

  task automatic req(bit [31:0] va, bit by, bit wr);
    quiet(); req_valid = 1; req_vaddr = va; req_byte = by; req_write = wr;
    req_wdata = $urandom; mem_rdata = $urandom;
    step(); quiet(); step();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_v[i] = 0; m_w[i] = 0; m_tag[i] = 0; m_frm[i] = 0;
    end
    // R12 reset state
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 R4 R5 R9
    req(32'h0001_0000, 0, 0);
    fill(16, 'h00abc, 1);
    fill(17, 'h00abd, 0);
    req(32'h0001_0124, 0, 0);
    req(32'h0001_1ffc, 0, 0);
    req(32'h0001_1ffc, 0, 1);
    req(32'h0001_0008, 0, 1);
    // R2 R3 R13
    req(32'h0005_0002, 0, 0);
    req(32'h0001_0003, 0, 1);
    for (int l = 0; l < 4; l++) req(32'h0001_0010 + l, 1, 1);
    for (int l = 0; l < 4; l++) req(32'h0001_1010 + l, 1, 0);
    // R9 refill overwrite
    fill(17, 'h11111, 1);
    req(32'h0001_1000, 0, 1);
    // R8 single invalidate, miss and hit
    quiet(); inv_one = 1; inv_vaddr = 32'h0009_9000; step(); quiet();
    req(32'h0001_0000, 0, 0);
    quiet(); inv_one = 1; inv_vaddr = 32'h0001_0fff; step(); quiet();
    req(32'h0001_0000, 0, 0);
    req(32'h0001_1000, 0, 0);
    // R10 round robin over full cache
    for (int v = 100; v < 120; v++) begin
      fill(v, v + 7, 1);
      req({12'h0, 20'(v - 9)} << 0 == 0 ? 32'h0 : {20'(v - 8), 12'h040}, 0, 0);
    end
    for (int v = 100; v < 120; v++) req({20'(v), 12'h000}, 0, 0);
    // R11 precedence
    quiet(); inv_one = 1; inv_vaddr = {20'd119, 12'h0}; fill_valid = 1; fill_vpn = 20'd300; fill_pfn = 20'd5;
    step(); quiet();
    req({20'd119, 12'h0}, 0, 0);
    req({20'd300, 12'h0}, 0, 0);
    quiet(); inv_all = 1; fill_valid = 1; fill_vpn = 20'd301; step(); quiet();
    req({20'd301, 12'h0}, 0, 0);
    req({20'd118, 12'h0}, 0, 0);
    // R6 R7
    fill(40, 41, 1);
    quiet(); inv_all = 1; step(); quiet();
    req({20'd40, 12'h0}, 0, 0);
    fill(40, 41, 1);
    quiet(); ptb_we = 1; ptb_wdata = 32'hCAFE_0000; step(); quiet();
    req({20'd40, 12'h0}, 0, 0);
    step();
    // mixed traffic, same-cycle lookups with maintenance
    for (int n = 0; n < 4000; n++) begin
      int r;
      quiet();
      r = $urandom % 100;
      req_valid = ($urandom % 3) != 0;
      req_vaddr = {20'($urandom % 24), 12'($urandom)};
      req_byte = $urandom; req_write = $urandom;
      req_wdata = $urandom; mem_rdata = $urandom;
      if (r < 35) begin
        fill_valid = 1; fill_vpn = 20'($urandom % 24); fill_pfn = 20'($urandom); fill_writable = $urandom;
      end
      if (r >= 35 && r < 45) begin inv_one = 1; inv_vaddr = {20'($urandom % 24), 12'($urandom)}; end
      if (r == 45) inv_all = 1;
      if (r == 46) begin ptb_we = 1; ptb_wdata = $urandom; end
      if (r > 46 && r < 50) begin fill_valid = 1; inv_one = 1; fill_vpn = 20'($urandom % 24); inv_vaddr = {20'($urandom % 24), 12'h0}; end
      step();
    end
    quiet(); step(); step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule